// File: doc/BRIEF.md
# SDRAM Column Burst Engine

This block is the device-side column logic of a single-bank synchronous DRAM. It samples the four command pins on every rising clock edge. It opens and closes one row, and it runs read and write bursts across the columns of that row. Each burst takes its length from `burst_len_i`, and read data waits in a latency pipeline whose depth follows `cas_lat_i`. A small internal array stores the data.

A burst can be cut short in three ways. A new read or write restarts the burst at a new column. A precharge ends the burst and closes the row. A burst stop ends the burst but leaves the row open. Read beats already in the latency pipeline always drain, so after a burst stop the output enable falls exactly CAS-latency cycles later. A write beat presented in the same cycle as a burst stop, or in any later cycle, is never stored.

Top module: `sdram_burst_engine`

## Requirements
- R1: The command is decoded from {cs_ni, ras_ni, cas_ni, we_ni} at each rising edge, as follows:
  - 0111 is NOP.
  - 0011 is ACTIVE.
  - 0101 is READ.
  - 0100 is WRITE.
  - 0010 is PRECHARGE.
  - 0110 is BURST STOP.
  - Any pattern with cs_ni high is a deselect and acts as NOP.
- R2: After reset no row is open. ACTIVE opens the row given by addr_i[ROW_W-1:0], and row_open_o is high from the next cycle. PRECHARGE closes the row.
- R3: A READ or WRITE issued while no row is open is ignored. Nothing is stored and nothing is driven. proto_err_o is high for exactly the one cycle after that command.
- R4: Beat k of a read issued at edge E is driven on dq_o, with dq_oe_o high, during the cycle after edge E+k+CL-1. CL is cas_lat_i, with values 1, 2 or 3 (a value of 0 acts as 1).
- R5: burst_len_i selects the burst length, sampled with the command:
  - code 0 gives 1 beat.
  - code 1 gives 2 beats.
  - code 2 gives 4 beats.
  - code 3 gives 8 beats.
  - code 7 gives a full page of 2**COL_W beats.
  - Any other code gives 1 beat.

  Columns step up by one and wrap inside the block of the burst length that holds the start column.
- R6: Write beat k is taken from dq_i at edge E+k, where E is the WRITE edge, and stored at the column of that beat.
- R7: A burst stop during a read drives every beat issued before the stop edge. dq_oe_o is low from the cycle after stop edge + CL - 1, and the row stays open.
- R8: A burst stop during a write stores only the beats before the stop edge. The dq_i value at the stop edge and at later edges is discarded, and the row stays open.
- R9: A READ issued during a burst ends the old burst. Its first beat takes the place of the old burst's beat at that edge.
- R10: A PRECHARGE during a read ends the burst and closes the row. Beats already issued still appear at their latency.
- R11: An uninterrupted burst ends after its length in beats. dq_oe_o falls CL cycles after the last beat is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; commands sampled on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Row on ACTIVE, start column on READ/WRITE |
| cas_lat_i | input | CLW | Read latency in cycles |
| burst_len_i | input | 3 | Burst length code |
| dq_i | input | DATA_W | Write data |
| dq_o | output | DATA_W | Read data, zero when not driven |
| dq_oe_o | output | 1 | Read data output enable (high means driven) |
| row_open_o | output | 1 | A row is open |
| proto_err_o | output | 1 | Pulse after a column command to a closed bank |

## Verification
The bench aims at the edge where a burst stop lands, at every CAS latency. If a design issues the beat at the stop edge, or flushes beats already in flight, dq_oe_o drops one cycle late or one cycle early. Write bursts are stopped mid-stream and then read back. A design that stores the coincident beat leaves 0xEE in the array. Another test interrupts a read with a new read, where a wrong design would show an extra stale beat or a gap in the data. Column wrap is tested from start columns that are not aligned, and there a wrong design reads past the end of the burst block. Accesses are also made to a closed bank, where a design with broken row tracking would either write the array or fail to flag the error.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_BST
  } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_burst_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    casez ({cs_ni, ras_ni, cas_ni, we_ni})
      4'b1???: cmd_o = CMD_NOP;
      4'b0011: cmd_o = CMD_ACT;
      4'b0101: cmd_o = CMD_RD;
      4'b0100: cmd_o = CMD_WR;
      4'b0010: cmd_o = CMD_PRE;
      4'b0110: cmd_o = CMD_BST;
      default: cmd_o = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen #(
  parameter int COL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  output logic             issue_o,
  output logic [COL_W-1:0] issue_col_o
);
  localparam int CNT_W = COL_W + 1;

  logic             active_q;
  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] mask_q;
  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] beats;
  logic [COL_W-1:0] mask_new;

  function automatic logic [COL_W-1:0] wrap_inc(input logic [COL_W-1:0] c,
                                                input logic [COL_W-1:0] m);
    return (c & ~m) | ((c + 1'b1) & m);
  endfunction

  always_comb begin
    case (bl_code_i)
      3'd1:    beats = CNT_W'(2);
      3'd2:    beats = CNT_W'(4);
      3'd3:    beats = CNT_W'(8);
      3'd7:    beats = CNT_W'(1) << COL_W;
      default: beats = CNT_W'(1);
    endcase
    mask_new = COL_W'(beats - 1'b1);
  end

  // start overrides a stop or a running burst: restart at new column
  assign issue_o     = start_i | (active_q & ~stop_i);
  assign issue_col_o = start_i ? start_col_i : col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      col_q    <= '0;
      mask_q   <= '0;
      left_q   <= '0;
    end else if (start_i) begin
      active_q <= beats > CNT_W'(1);
      col_q    <= wrap_inc(start_col_i, mask_new);
      mask_q   <= mask_new;
      left_q   <= beats - 1'b1;
    end else if (stop_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      col_q    <= wrap_inc(col_q, mask_q);
      left_q   <= left_q - 1'b1;
      active_q <= left_q != CNT_W'(1);
    end
  end
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int DATA_W = 8,
  parameter int MAX_CL = 3,
  parameter int CLW    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CLW-1:0]    cl_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o
);
  logic [MAX_CL-1:0] vld_q;
  logic [DATA_W-1:0] dat_q [MAX_CL];

  for (genvar g = 0; g < MAX_CL; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[0] <= 1'b0;
          dat_q[0] <= '0;
        end else begin
          vld_q[0] <= vld_i;
          dat_q[0] <= vld_i ? data_i : '0;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[g] <= 1'b0;
          dat_q[g] <= '0;
        end else begin
          vld_q[g] <= vld_q[g-1];
          dat_q[g] <= dat_q[g-1];
        end
      end
    end
  end

  int sel;
  always_comb begin
    if (cl_i == '0)                 sel = 0;
    else if (int'(cl_i) > MAX_CL)   sel = MAX_CL - 1;
    else                            sel = int'(cl_i) - 1;
    vld_o  = 1'b0;
    data_o = '0;
    for (int i = 0; i < MAX_CL; i++) begin
      if (i == sel) begin
        vld_o  = vld_q[i];
        data_o = dat_q[i];
      end
    end
  end
endmodule

// File: rtl/sdram_mem_array.sv
module sdram_mem_array #(
  parameter int AW     = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/sdram_burst_engine.sv
module sdram_burst_engine
  import sdram_burst_pkg::*;
#(
  parameter int ROW_W  = 2,
  parameter int COL_W  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int MAX_CL = 3,
  parameter int CLW    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CLW-1:0]    cas_lat_i,
  input  logic [2:0]        burst_len_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              row_open_o,
  output logic              proto_err_o
);
  localparam int AW = ROW_W + COL_W;

  cmd_e             cmd;
  logic             is_rd, is_wr, start, stop, issue;
  logic             rd_issue, wr_en;
  logic             wr_q, row_open_q, err_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] issue_col;
  logic [DATA_W-1:0] rdata;

  sdram_cmd_decode u_dec (
    .cs_ni (cs_ni),
    .ras_ni(ras_ni),
    .cas_ni(cas_ni),
    .we_ni (we_ni),
    .cmd_o (cmd)
  );

  assign is_rd = (cmd == CMD_RD);
  assign is_wr = (cmd == CMD_WR);
  assign start = (is_rd | is_wr) & row_open_q;
  assign stop  = (cmd == CMD_PRE) | (cmd == CMD_BST);

  sdram_burst_gen #(.COL_W(COL_W)) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .stop_i     (stop),
    .start_col_i(addr_i[COL_W-1:0]),
    .bl_code_i  (burst_len_i),
    .issue_o    (issue),
    .issue_col_o(issue_col)
  );

  assign rd_issue = issue & (start ? is_rd : ~wr_q);
  assign wr_en    = issue & (start ? is_wr : wr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q       <= 1'b0;
      row_open_q <= 1'b0;
      row_q      <= '0;
      err_q      <= 1'b0;
    end else begin
      if (start) wr_q <= is_wr;
      if (cmd == CMD_ACT) begin
        row_open_q <= 1'b1;
        row_q      <= addr_i[ROW_W-1:0];
      end else if (cmd == CMD_PRE) begin
        row_open_q <= 1'b0;
      end
      err_q <= (is_rd | is_wr) & ~row_open_q;
    end
  end

  sdram_mem_array #(.AW(AW), .DATA_W(DATA_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (wr_en),
    .addr_i ({row_q, issue_col}),
    .wdata_i(dq_i),
    .rdata_o(rdata)
  );

  sdram_rd_pipe #(.DATA_W(DATA_W), .MAX_CL(MAX_CL), .CLW(CLW)) u_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (rd_issue),
    .data_i(rdata),
    .cl_i  (cas_lat_i),
    .vld_o (dq_oe_o),
    .data_o(dq_o)
  );

  assign row_open_o  = row_open_q;
  assign proto_err_o = err_q;
endmodule

// File: rtl/sdram_burst_engine_chk.sv
module sdram_burst_engine_chk #(
  parameter int CLW = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cs_ni,
  input logic           ras_ni,
  input logic           cas_ni,
  input logic           we_ni,
  input logic [CLW-1:0] cas_lat_i,
  input logic           dq_oe_o,
  input logic           row_open_o,
  input logic           proto_err_o,
  input logic           rd_issue,
  input logic           wr_en
);
  logic act_c, rd_c, wr_c, pre_c, bst_c;
  assign act_c = !cs_ni && !ras_ni &&  cas_ni &&  we_ni;
  assign rd_c  = !cs_ni &&  ras_ni && !cas_ni &&  we_ni;
  assign wr_c  = !cs_ni &&  ras_ni && !cas_ni && !we_ni;
  assign pre_c = !cs_ni && !ras_ni &&  cas_ni && !we_ni;
  assign bst_c = !cs_ni &&  ras_ni &&  cas_ni && !we_ni;

  assert_act_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_c |=> row_open_o);

  assert_pre_closes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_c |=> !row_open_o);

  assert_bst_keeps_row_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bst_c && row_open_o) |=> row_open_o);

  assert_bst_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bst_c || pre_c) |-> !wr_en);

  assert_bst_no_issue_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bst_c || pre_c) |-> !rd_issue);

  assert_err_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> $past((rd_c || wr_c) && !row_open_o));

  assert_cl1_timing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_lat_i == CLW'(1) && $past(cas_lat_i) == CLW'(1)) |-> (dq_oe_o == $past(rd_issue)));
endmodule

bind sdram_burst_engine sdram_burst_engine_chk #(.CLW(CLW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .ras_ni     (ras_ni),
  .cas_ni     (cas_ni),
  .we_ni      (we_ni),
  .cas_lat_i  (cas_lat_i),
  .dq_oe_o    (dq_oe_o),
  .row_open_o (row_open_o),
  .proto_err_o(proto_err_o),
  .rd_issue   (rd_issue),
  .wr_en      (wr_en)
);

// File: tb/sdram_burst_engine_tb.sv
module sdram_burst_engine_tb;
  localparam int ROW_W = 2, COL_W = 4, ADDR_W = 4, DATA_W = 8, CLW = 2;
  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_BST = 5, C_DES = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n, ras_n, cas_n, we_n;
  logic [ADDR_W-1:0] addr;
  logic [CLW-1:0]    cl_r;
  logic [2:0]        bl_r;
  logic [DATA_W-1:0] dq_in, dq_out;
  logic oe, row_open, perr;

  always #4 clk = ~clk;

  sdram_burst_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .addr_i(addr), .cas_lat_i(cl_r), .burst_len_i(bl_r),
    .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(oe), .row_open_o(row_open),
    .proto_err_o(perr)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [DATA_W-1:0] mem_m [1 << (ROW_W + COL_W)];
  logic open_m = 1'b0;
  logic [ROW_W-1:0] row_m = '0;

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pins(input int c, input logic [ADDR_W-1:0] a);
    addr = a;
    case (c)
      C_ACT:   {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      C_RD:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      C_WR:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      C_PRE:   {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      C_BST:   {cs_n, ras_n, cas_n, we_n} = 4'b0110;
      C_DES:   {cs_n, ras_n, cas_n, we_n} = 4'b1101;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    endcase
  endtask

  function automatic int beats(input logic [2:0] code);
    case (code)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 1 << COL_W;
      default: return 1;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] colk(input logic [COL_W-1:0] s, input int b, input int k);
    logic [COL_W-1:0] m;
    m = COL_W'(b - 1);
    return (s & ~m) | ((s + COL_W'(k)) & m);
  endfunction

  // kind: 0 none, 1 burst stop, 2 new read at col2, 3 precharge; s = interrupt cycle
  task automatic do_read(input int cl, input logic [2:0] blc, input logic [COL_W-1:0] col,
                         input int kind, input int s, input logic [COL_W-1:0] col2,
                         input string req);
    bit ev [64];
    logic [COL_W-1:0] ec [64];
    int b, lim;
    b = beats(blc);
    for (int i = 0; i < 64; i++) begin
      ev[i] = 1'b0;
      ec[i] = '0;
      if (open_m) begin
        if (kind == 0 && i < b) begin
          ev[i] = 1'b1; ec[i] = colk(col, b, i);
        end else if ((kind == 1 || kind == 3) && i < b && i < s) begin
          ev[i] = 1'b1; ec[i] = colk(col, b, i);
        end else if (kind == 2) begin
          if (i < s && i < b) begin
            ev[i] = 1'b1; ec[i] = colk(col, b, i);
          end else if (i >= s && i - s < b) begin
            ev[i] = 1'b1; ec[i] = colk(col2, b, i - s);
          end
        end
      end
    end
    lim = (kind == 2 ? s : 0) + b + cl + 3;
    @(negedge clk);
    cl_r = CLW'(cl);
    bl_r = blc;
    pins(C_RD, ADDR_W'(col));
    for (int n = 1; n < lim; n++) begin
      int k;
      logic eo;
      @(negedge clk);
      if (n == 1) check("R3 error flag on read", 32'(perr), 32'(!open_m));
      k = n - cl;
      eo = (k >= 0) ? ev[k] : 1'b0;
      check({req, " output enable"}, 32'(oe), 32'(eo));
      if (eo) check({req, " read data"}, 32'(dq_out), 32'(mem_m[{row_m, ec[k]}]));
      if (n == s && kind == 1)      pins(C_BST, '0);
      else if (n == s && kind == 2) pins(C_RD, ADDR_W'(col2));
      else if (n == s && kind == 3) pins(C_PRE, '0);
      else                          pins(C_NOP, '0);
    end
    if (kind == 3) open_m = 1'b0;
    check({req, " row state"}, 32'(row_open), 32'(open_m));
  endtask

  // s < 0 means no burst stop
  task automatic do_write(input logic [2:0] blc, input logic [COL_W-1:0] col, input int s,
                          input logic [DATA_W-1:0] base, input string req);
    int b;
    b = beats(blc);
    @(negedge clk);
    bl_r = blc;
    pins(C_WR, ADDR_W'(col));
    dq_in = base;
    for (int n = 1; n <= b + 1; n++) begin
      @(negedge clk);
      if (n == 1) check({req, " error flag on write"}, 32'(perr), 32'(!open_m));
      if (n == s) pins(C_BST, '0);
      else        pins(C_NOP, '0);
      dq_in = ((s > 0 && n >= s) || n >= b) ? 8'hEE : base + DATA_W'(n);
    end
    if (open_m)
      for (int i = 0; i < b; i++)
        if (s < 0 || i < s) mem_m[{row_m, colk(col, b, i)}] = base + DATA_W'(i);
    check({req, " row state after write"}, 32'(row_open), 32'(open_m));
  endtask

  task automatic do_act(input logic [ROW_W-1:0] r);
    @(negedge clk);
    pins(C_ACT, ADDR_W'(r));
    @(negedge clk);
    pins(C_NOP, '0);
    row_m = r;
    open_m = 1'b1;
    check("R2 row opens after ACTIVE", 32'(row_open), 32'(1));
  endtask

  task automatic t_reset();
    check("R2 reset row closed", 32'(row_open), 32'(0));
    check("R4 reset output enable low", 32'(oe), 32'(0));
    check("R3 reset error flag low", 32'(perr), 32'(0));
  endtask

  task automatic t_deselect();
    @(negedge clk);
    cl_r = CLW'(1);
    pins(C_DES, '0);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      pins(C_NOP, '0);
      check("R1 deselect gives no read output", 32'(oe), 32'(0));
      check("R1 deselect gives no error", 32'(perr), 32'(0));
    end
  endtask

  initial begin
    pins(C_NOP, '0);
    cl_r = CLW'(1);
    bl_r = 3'd0;
    dq_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    // R3: closed bank
    do_read(1, 3'd1, 4'd0, 0, 0, 4'd0, "R3");
    do_write(3'd1, 4'd0, -1, 8'h99, "R3");
    do_act(2'd1);
    t_deselect();
    // fill page (R6) and plain reads (R4 R5 R11)
    do_write(3'd7, 4'd0, -1, 8'h40, "R6");
    do_read(1, 3'd7, 4'd0, 0, 0, 4'd0, "R4");
    do_read(2, 3'd3, 4'd5, 0, 0, 4'd0, "R5");
    do_read(3, 3'd2, 4'd14, 0, 0, 4'd0, "R5");
    do_read(2, 3'd0, 4'd9, 0, 0, 4'd0, "R11");
    do_read(3, 3'd1, 4'd3, 0, 0, 4'd0, "R11");
    // burst stop on reads
    do_read(1, 3'd3, 4'd0, 1, 3, 4'd0, "R7");
    do_read(2, 3'd3, 4'd2, 1, 3, 4'd0, "R7");
    do_read(3, 3'd3, 4'd4, 1, 3, 4'd0, "R7");
    do_read(3, 3'd7, 4'd6, 1, 5, 4'd0, "R7");
    // burst stop on write, then read back without new ACTIVE
    do_write(3'd3, 4'd8, 3, 8'h80, "R8");
    do_read(2, 3'd3, 4'd8, 0, 0, 4'd0, "R8");
    // read interrupted by read
    do_read(2, 3'd3, 4'd0, 2, 3, 4'd12, "R9");
    do_read(1, 3'd2, 4'd1, 2, 1, 4'd9, "R9");
    // precharge mid read
    do_read(3, 3'd3, 4'd4, 3, 2, 4'd0, "R10");
    do_write(3'd1, 4'd0, -1, 8'h11, "R3");
    do_act(2'd1);
    do_read(1, 3'd1, 4'd0, 0, 0, 4'd0, "R3");
    repeat (3) @(negedge clk);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule